// File: doc/BRIEF.md
# Gated clock-enable divider bank

The bank drives sixteen independent clock-enable outputs inside one system clock domain. Each output channel picks one of four incoming enable strobes and passes every 2^v-th strobe of it, where v is the channel's divide code. Each channel can also be shut off. All settings live in three 32-bit control words reached through a simple write/read port, and each channel owns a fixed slice of every word.

Downstream logic uses an output strobe as a one-cycle qualifier, in place of a derived clock. A channel that is shut off holds its count at zero, so it resumes from a clean phase. A write that changes a channel's source or divide code restarts that channel alone.

Top module: `clk_div_bank`

## Requirements
- R1: After reset all three control words read zero, so every channel is on, takes source 0 and divides by 1.
- R2: The shut-off word sits at byte address 0x0, the source word at 0x4 and the divide word at 0x8. A write with `bus_we_i` high replaces the whole addressed word at the clock edge, and `bus_rdata_o` shows the whole addressed word in the same cycle.
- R3: Every other address reads zero, and a write to it changes none of the three words.
- R4: Bit i of the shut-off word set to 1 turns channel i off and clears its count. From the second clock edge after the write edge onward, `chan_pulse_o[i]` stays low.
- R5: Bits [2i+1:2i] of the source word pick which bit of `src_en_i` channel i counts.
- R6: Bits [2i+1:2i] of the divide word hold code v. Channel i pulses on every 2^v-th counted strobe (1, 2, 4 or 8), and the first pulse after a restart comes on the 2^v-th strobe.
- R7: A pulse is registered. `chan_pulse_o[i]` is high in the cycle that follows the edge which sampled the qualifying strobe, and it is never high without one.
- R8: A write that changes channel i's source slice or divide slice clears channel i's count at that edge, and a strobe in the write cycle is not counted. Channels whose slices keep their value continue counting undisturbed.
- R9: When a channel is turned back on, counting starts from zero. With divide code v and a strobe every cycle, the first pulse appears 2^v cycles after the first enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_en_i | input | 4 | Incoming enable strobes, one per source |
| bus_we_i | input | 1 | Write strobe for the control port |
| bus_addr_i | input | 4 | Byte address of the control word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| chan_pulse_o | output | 16 | One enable strobe per channel |

## Verification
A wrong count or a stale source shows up on the pulse outputs within at most eight strobes of the affected channel. With the slow sources this is at most a few dozen cycles, so each output is compared with an independent cycle model on every edge. A missed restart after a source or divide write shifts the pulse phase of that channel alone, and the model catches this from the first strobe that follows. A corrupted control word shows at once on the read port, and within one strobe as a misplaced pulse.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
  localparam int unsigned OFS_GATE = 0;
  localparam int unsigned OFS_SEL  = 4;
  localparam int unsigned OFS_DIV  = 8;

  typedef enum logic [1:0] {
    REG_GATE,
    REG_SEL,
    REG_DIV,
    REG_NONE
  } reg_id_e;
endpackage

// File: rtl/clkbank_regs.sv
module clkbank_regs
  import clkbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DIV_W  = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [NUM_CH-1:0]         gate_o,
  output logic [NUM_CH*SEL_W-1:0]   sel_o,
  output logic [NUM_CH*DIV_W-1:0]   div_o,
  output logic [NUM_CH-1:0]         restart_o
);
  logic [DATA_W-1:0] gate_q, sel_q, div_q;
  reg_id_e           reg_id;

  always_comb begin
    if (addr_i == ADDR_W'(OFS_GATE))     reg_id = REG_GATE;
    else if (addr_i == ADDR_W'(OFS_SEL)) reg_id = REG_SEL;
    else if (addr_i == ADDR_W'(OFS_DIV)) reg_id = REG_DIV;
    else                                 reg_id = REG_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      sel_q  <= '0;
      div_q  <= '0;
    end else if (we_i) begin
      case (reg_id)
        REG_GATE: gate_q <= wdata_i;
        REG_SEL:  sel_q  <= wdata_i;
        REG_DIV:  div_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_id)
      REG_GATE: rdata_o = gate_q;
      REG_SEL:  rdata_o = sel_q;
      REG_DIV:  rdata_o = div_q;
      default:  rdata_o = '0;
    endcase
  end

  assign gate_o = gate_q[NUM_CH-1:0];
  assign sel_o  = sel_q[NUM_CH*SEL_W-1:0];
  assign div_o  = div_q[NUM_CH*DIV_W-1:0];

  // restart only channels whose own slice changes
  for (genvar c = 0; c < NUM_CH; c++) begin : g_restart
    logic sel_chg, div_chg;
    assign sel_chg = (reg_id == REG_SEL) &&
                     (wdata_i[c*SEL_W +: SEL_W] != sel_q[c*SEL_W +: SEL_W]);
    assign div_chg = (reg_id == REG_DIV) &&
                     (wdata_i[c*DIV_W +: DIV_W] != div_q[c*DIV_W +: DIV_W]);
    assign restart_o[c] = we_i && (sel_chg || div_chg);
  end

  assert_unmapped_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && reg_id == REG_NONE) |=>
      (gate_q == $past(gate_q) && sel_q == $past(sel_q) && div_q == $past(div_q)));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (gate_q == $past(gate_q) && sel_q == $past(sel_q) && div_q == $past(div_q)));
endmodule

// File: rtl/clkbank_chan.sv
module clkbank_chan #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned DIV_W = 2,
  localparam int unsigned NUM_SRC = 1 << SEL_W,
  localparam int unsigned CNT_W   = (1 << DIV_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               gate_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               restart_i,
  output logic               pulse_o
);
  logic [CNT_W-1:0] cnt_q, lim;
  logic             pulse_q, src_hit, count_en;

  always_comb begin
    lim = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b < int'(div_i)) lim[b] = 1'b1;
    end
  end

  assign src_hit  = src_i[sel_i];
  assign count_en = src_hit && !gate_i && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (gate_i || restart_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (src_hit) begin
      if (cnt_q >= lim) begin
        cnt_q   <= '0;
        pulse_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + CNT_W'(1);
        pulse_q <= 1'b0;
      end
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;

  assert_gate_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i |=> (!pulse_o && cnt_q == '0));

  assert_pulse_needs_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_en |=> !pulse_o);

  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);

  assert_restart_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0 && !pulse_o));
endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DIV_W  = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NUM_SRC = 1 << SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic [NUM_CH-1:0]  chan_pulse_o
);
  logic [NUM_CH-1:0]       gate, restart;
  logic [NUM_CH*SEL_W-1:0] sel;
  logic [NUM_CH*DIV_W-1:0] div;

  clkbank_regs #(
    .NUM_CH(NUM_CH), .SEL_W(SEL_W), .DIV_W(DIV_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .gate_o   (gate),
    .sel_o    (sel),
    .div_o    (div),
    .restart_o(restart)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    clkbank_chan #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_en_i),
      .gate_i   (gate[c]),
      .sel_i    (sel[c*SEL_W +: SEL_W]),
      .div_i    (div[c*DIV_W +: DIV_W]),
      .restart_i(restart[c]),
      .pulse_o  (chan_pulse_o[c])
    );
  end

  initial begin
    assert_fit_R2: assert (NUM_CH * SEL_W <= DATA_W && NUM_CH * DIV_W <= DATA_W && NUM_CH <= DATA_W);
  end
endmodule

// File: tb/clk_div_bank_bench.sv
module clk_div_bank_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  src = '0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pulse;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic [7:0] lfsr = 8'h5A;
  bit done = 0;

  logic [31:0] m_gate = '0, m_sel = '0, m_div = '0;
  int          m_cnt [16];
  logic [15:0] m_pulse = '0;

  always #2.5 clk = ~clk;

  clk_div_bank u_clk_div_bank (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .src_en_i    (src),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .chan_pulse_o(pulse)
  );

  // {gate, select, divide}
  localparam logic [95:0] VEC [5] = '{
    {32'h0000_0000, 32'hE4E4_E4E4, 32'h1B1B_1B1B},
    {32'h0000_AAAA, 32'h5555_5555, 32'hFFFF_FFFF},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h5555_5555},
    {32'h0000_F0F0, 32'hAAAA_AAAA, 32'hAAAA_AAAA},
    {32'h0000_0000, 32'hE4E4_E4E4, 32'h0000_0000}
  };

  function automatic logic [3:0] src_pat(int c, logic [7:0] l);
    return {l[0], (c % 3) == 0, (c % 2) == 0, 1'b1};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one clock cycle with optional write; model runs the same edge
  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    we = w; addr = a; wdata = d;
    src = src_pat(cyc, lfsr);
    for (int i = 0; i < 16; i++) begin
      logic [1:0] sl, dv;
      logic rs;
      int lim;
      sl = m_sel[2*i +: 2];
      dv = m_div[2*i +: 2];
      rs = w && ((a == 4'h4 && d[2*i +: 2] != sl) || (a == 4'h8 && d[2*i +: 2] != dv));
      lim = (1 << dv) - 1;
      if (m_gate[i] || rs) begin
        m_cnt[i] = 0; m_pulse[i] = 1'b0;
      end else if (src[sl]) begin
        if (m_cnt[i] >= lim) begin m_cnt[i] = 0; m_pulse[i] = 1'b1; end
        else begin m_cnt[i]++; m_pulse[i] = 1'b0; end
      end else m_pulse[i] = 1'b0;
    end
    if (w) begin
      case (a)
        4'h0: m_gate = d;
        4'h4: m_sel  = d;
        4'h8: m_div  = d;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    check(tag, {16'h0, pulse}, {16'h0, m_pulse});
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    we = 1'b0; addr = a;
    #0.2;
    check(tag, rdata, exp);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #0.5;
    // R1: reset state
    rd_chk(4'h0, 32'h0, "R1 gate word after reset");
    rd_chk(4'h4, 32'h0, "R1 select word after reset");
    rd_chk(4'h8, 32'h0, "R1 divide word after reset");
    step(1'b0, 4'h0, 32'h0, "R1 R7 first pulses after reset");
    check("R1 all channels follow source 0", {16'h0, pulse}, 32'h0000_FFFF);
    repeat (4) step(1'b0, 4'h0, 32'h0, "R1 R7 steady divide-by-1");

    // vector table: R2 R5 R6 R7 R8 R4
    for (int v = 0; v < 5; v++) begin
      step(1'b1, 4'h0, VEC[v][95:64], "R4 gate write");
      step(1'b1, 4'h4, VEC[v][63:32], "R5 R8 select write");
      step(1'b1, 4'h8, VEC[v][31:0],  "R6 R8 divide write");
      rd_chk(4'h0, VEC[v][95:64], "R2 gate readback");
      rd_chk(4'h4, VEC[v][63:32], "R2 select readback");
      rd_chk(4'h8, VEC[v][31:0],  "R2 divide readback");
      for (int k = 0; k < 24; k++) step(1'b0, 4'h0, 32'h0, "R5 R6 R7 pulse pattern");
    end

    // R3: unmapped addresses
    step(1'b1, 4'hC, 32'hFFFF_FFFF, "R3 write to unmapped 0xC");
    step(1'b1, 4'h2, 32'hFFFF_FFFF, "R3 write to unmapped 0x2");
    rd_chk(4'hC, 32'h0, "R3 unmapped 0xC reads zero");
    rd_chk(4'h6, 32'h0, "R3 unmapped 0x6 reads zero");
    rd_chk(4'h0, m_gate, "R3 gate word untouched");
    rd_chk(4'h4, m_sel,  "R3 select word untouched");
    rd_chk(4'h8, m_div,  "R3 divide word untouched");

    // R8: only channel 0's divide slice changes
    step(1'b1, 4'h4, 32'h0, "R8 all on source 0");
    step(1'b1, 4'h8, 32'hAAAA_AAAA, "R8 all divide by 4");
    step(1'b0, 4'h0, 32'h0, "R8 counting");
    step(1'b1, 4'h8, 32'hAAAA_AAA9, "R8 restart channel 0 only");
    for (int k = 0; k < 12; k++) step(1'b0, 4'h0, 32'h0, "R8 phase after single restart");

    // R4: everything off
    step(1'b1, 4'h0, 32'h0000_FFFF, "R4 gate all");
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 4'h0, 32'h0, "R4 gated model");
      check("R4 gated outputs low", {16'h0, pulse}, 32'h0);
    end

    // R9: re-enable channel 0 at divide by 4 on the always-on source
    step(1'b1, 4'h8, 32'h0000_0002, "R9 ch0 divide by 4");
    step(1'b1, 4'h0, 32'h0000_FFFE, "R9 ungate ch0");
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 4'h0, 32'h0, "R9 restart model");
      check("R9 ch0 first pulse on 4th edge", {31'h0, pulse[0]}, (k == 3) ? 32'h1 : 32'h0);
    end
    for (int k = 0; k < 8; k++) step(1'b0, 4'h0, 32'h0, "R9 steady after re-enable");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired (cycle %0d)", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule